// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a 9-bit first-in first-out buffer. Its write port and its read port each have their own clock. The two clocks may be the same net, or they may be unrelated. Each side has a pair of enables, and both enables of a pair must be active for a transfer to happen.

On the write side, one enable is active low and the other is active high. The active-high write enable has a second job: it is the load strobe for two level offsets. One offset sets the almost-empty threshold and the other sets the almost-full threshold. On the read side, both enables are active low. A popped word is held in an output register. An output-enable input decides whether that register is driven onto the data port or whether the port is shown as released.

Pointers pass between the clock domains in Gray code through two-stage synchronizers. Fill and vacancy are then computed separately on each side:
- The write side produces the full and almost-full flags.
- The read side produces the empty and almost-empty flags.

Top module: `dcfifo_pflag`

## Requirements
- R1: While `rst` is high and at the first edge after it falls, `empty` and `almost_empty` read 1, `full` and `almost_full` read 0, and `rd_data` reads 0 with `out_en` high.
- R2: On a rising `wr_clk` edge with `wr_en_n`=0 and `wr_ld`=1, the FIFO stores `wr_data`. On a rising `rd_clk` edge with `rd_en_a_n`=0 and `rd_en_b_n`=0, it pops the oldest word into the output register. Words leave in the order they were written.
- R3: A write attempted while `full`=1 is discarded. The stored contents and their order stay unchanged.
- R4: A read attempted while `empty`=1 has no effect, and `rd_data` keeps its previous word.
- R5: A read with only one of `rd_en_a_n`/`rd_en_b_n` low pops nothing and leaves `rd_data` unchanged.
- R6: `full` is 1 exactly when 2**ADDR_W words (64 by default) are stored. `empty` is 1 exactly when no word is stored, once both pointer views have settled.
- R7: `almost_empty` is 1 when the stored count is at or below the almost-empty offset. `almost_full` is 1 when the free space is at or below the almost-full offset. Both offsets default to 7.
- R8: If `wr_ld` is 0 while `rst` is high, the block enters load mode. In load mode, each rising `wr_clk` edge with `wr_en_n`=0 and `wr_ld`=0 copies the low ADDR_W+1 bits of `wr_data` into an offset. The almost-empty offset is loaded first, then the almost-full offset, and the order then alternates. Writes with `wr_ld`=1 still work as in R2.
- R9: With `out_en`=0, `rd_data` reads 0 and `rd_drive` reads 0. The held word is not disturbed and reappears when `out_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_en_n | input | 1 | Write enable, active low |
| wr_ld | input | 1 | Write enable, active high; when low it acts as the offset load strobe |
| wr_data | input | 9 | Write data, or offset value while loading |
| rd_en_a_n | input | 1 | First read enable, active low |
| rd_en_b_n | input | 1 | Second read enable, active low |
| out_en | input | 1 | Output enable for the data port |
| rd_data | output | 9 | Output register contents when enabled, otherwise 0 |
| rd_drive | output | 1 | High when the data port is driven, low when released |
| empty | output | 1 | No word stored (read domain) |
| almost_empty | output | 1 | Stored count at or below the almost-empty offset (read domain) |
| almost_full | output | 1 | Free space at or below the almost-full offset (write domain) |
| full | output | 1 | All entries occupied (write domain) |

## Verification
The assertions take for granted that `rst` is held high across at least one edge of each clock. They also assume that the offsets stay fixed while data is moving, because the almost-empty offset is read in the read domain without a synchronizer. The stimulus follows both assumptions: it loads offsets only immediately after reset, while the FIFO is empty, and it keeps reset high for several cycles. The stimulus ties the two clocks together, so the pointer synchronizers add a fixed two-cycle delay. Flags are therefore sampled only after a settling gap of four cycles.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DATA_W = 9;

    typedef logic [DATA_W-1:0] word_t;

    // Which offset register the next load strobe targets
    typedef enum logic {
        OFS_AE = 1'b0,
        OFS_AF = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        logic full;
        logic almost_full;
    } wr_flags_t;

    typedef struct packed {
        logic empty;
        logic almost_empty;
    } rd_flags_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DEFAULT_OFS = 7,
    localparam int CNT_W      = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_n,
    input  logic              wr_ld,
    input  word_t             wr_data,
    input  logic [CNT_W-1:0]  rgray_sync,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [CNT_W-1:0]  wptr,
    output logic [CNT_W-1:0]  wgray,
    output logic [CNT_W-1:0]  ae_ofs,
    output logic [CNT_W-1:0]  af_ofs,
    output wr_flags_t         flags
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(1 << ADDR_W);
    localparam logic [CNT_W-1:0] DEF_C   = CNT_W'(DEFAULT_OFS);

    logic             ld_mode;
    ofs_sel_e         ld_sel;
    logic [CNT_W-1:0] rptr_view;
    logic [CNT_W-1:0] used;
    logic [CNT_W-1:0] vacant;
    logic [CNT_W-1:0] wptr_nxt;
    logic             push;
    logic             load;

    assign rptr_view = CNT_W'(gray2bin(32'(rgray_sync)));
    assign used      = wptr - rptr_view;
    assign vacant    = DEPTH_C - used;

    assign flags.full        = (used == DEPTH_C);
    assign flags.almost_full = (vacant <= af_ofs);

    assign push     = !wr_en_n && wr_ld && !flags.full;
    assign load     = ld_mode && !wr_en_n && !wr_ld;
    assign wptr_nxt = wptr + 1'b1;

    assign mem_we    = push;
    assign mem_waddr = wptr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            wgray   <= '0;
            ld_mode <= !wr_ld;
            ld_sel  <= OFS_AE;
            ae_ofs  <= DEF_C;
            af_ofs  <= DEF_C;
        end else begin
            if (push) begin
                wptr  <= wptr_nxt;
                wgray <= CNT_W'(bin2gray(32'(wptr_nxt)));
            end
            if (load) begin
                if (ld_sel == OFS_AE) ae_ofs <= CNT_W'(wr_data);
                else                  af_ofs <= CNT_W'(wr_data);
                ld_sel <= (ld_sel == OFS_AE) ? OFS_AF : OFS_AE;
            end
        end
    end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int CNT_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_a_n,
    input  logic              rd_en_b_n,
    input  logic [CNT_W-1:0]  wgray_sync,
    input  logic [CNT_W-1:0]  ae_ofs,
    input  word_t             mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [CNT_W-1:0]  rptr,
    output logic [CNT_W-1:0]  rgray,
    output word_t             rd_q,
    output rd_flags_t         flags
);
    logic [CNT_W-1:0] wptr_view;
    logic [CNT_W-1:0] level;
    logic [CNT_W-1:0] rptr_nxt;
    logic             pop;

    assign wptr_view = CNT_W'(gray2bin(32'(wgray_sync)));
    assign level     = wptr_view - rptr;

    assign flags.empty        = (level == '0);
    assign flags.almost_empty = (level <= ae_ofs);

    assign pop       = !rd_en_a_n && !rd_en_b_n && !flags.empty;
    assign rptr_nxt  = rptr + 1'b1;
    assign mem_raddr = rptr[ADDR_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= '0;
            rgray <= '0;
            rd_q  <= '0;
        end else if (pop) begin
            rptr  <= rptr_nxt;
            rgray <= CNT_W'(bin2gray(32'(rptr_nxt)));
            rd_q  <= mem_rdata;
        end
    end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import dcf_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DEFAULT_OFS = 7
) (
    input  logic        wr_clk,
    input  logic        rd_clk,
    input  logic        rst,
    input  logic        wr_en_n,
    input  logic        wr_ld,
    input  logic [8:0]  wr_data,
    input  logic        rd_en_a_n,
    input  logic        rd_en_b_n,
    input  logic        out_en,
    output logic [8:0]  rd_data,
    output logic        rd_drive,
    output logic        empty,
    output logic        almost_empty,
    output logic        almost_full,
    output logic        full
);
    localparam int CNT_W = ADDR_W + 1;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] mem_raddr;
    word_t             mem_rdata;
    word_t             rd_q;
    logic [CNT_W-1:0]  wptr_bin;
    logic [CNT_W-1:0]  rptr_bin;
    logic [CNT_W-1:0]  wgray;
    logic [CNT_W-1:0]  rgray;
    logic [CNT_W-1:0]  wgray_rd;
    logic [CNT_W-1:0]  rgray_wr;
    logic [CNT_W-1:0]  ae_ofs;
    logic [CNT_W-1:0]  af_ofs;
    wr_flags_t         wflags;
    rd_flags_t         rflags;

    dcf_wr_ctl #(.ADDR_W(ADDR_W), .DEFAULT_OFS(DEFAULT_OFS)) u_wr (
        .clk        (wr_clk),
        .rst        (rst),
        .wr_en_n    (wr_en_n),
        .wr_ld      (wr_ld),
        .wr_data    (wr_data),
        .rgray_sync (rgray_wr),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .wptr       (wptr_bin),
        .wgray      (wgray),
        .ae_ofs     (ae_ofs),
        .af_ofs     (af_ofs),
        .flags      (wflags)
    );

    dcf_sync #(.W(CNT_W)) u_sync_r2w (
        .clk (wr_clk), .rst (rst), .d (rgray), .q (rgray_wr)
    );

    dcf_sync #(.W(CNT_W)) u_sync_w2r (
        .clk (rd_clk), .rst (rst), .d (wgray), .q (wgray_rd)
    );

    dcf_mem #(.ADDR_W(ADDR_W)) u_mem (
        .wclk  (wr_clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wr_data),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dcf_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .clk        (rd_clk),
        .rst        (rst),
        .rd_en_a_n  (rd_en_a_n),
        .rd_en_b_n  (rd_en_b_n),
        .wgray_sync (wgray_rd),
        .ae_ofs     (ae_ofs),
        .mem_rdata  (mem_rdata),
        .mem_raddr  (mem_raddr),
        .rptr       (rptr_bin),
        .rgray      (rgray),
        .rd_q       (rd_q),
        .flags      (rflags)
    );

    assign rd_data      = out_en ? rd_q : '0;
    assign rd_drive     = out_en;
    assign empty        = rflags.empty;
    assign almost_empty = rflags.almost_empty;
    assign full         = wflags.full;
    assign almost_full  = wflags.almost_full;
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
    parameter int CNT_W = 7
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             rst,
    input logic             wr_en_n,
    input logic             wr_ld,
    input logic             rd_en_a_n,
    input logic             rd_en_b_n,
    input logic             full,
    input logic             almost_full,
    input logic             empty,
    input logic             almost_empty,
    input logic [CNT_W-1:0] wptr,
    input logic [CNT_W-1:0] rptr,
    input logic [CNT_W-1:0] wgray,
    input logic [8:0]       rd_q
);
    // R1: flags leave reset in their idle state
    a_r1_reset_wr: assert property (@(posedge wr_clk) disable iff (rst)
        $fell(rst) |-> (!full && !almost_full));
    a_r1_reset_rd: assert property (@(posedge rd_clk) disable iff (rst)
        $fell(rst) |-> (empty && almost_empty));

    // R3: a write while full does not move the write pointer
    a_r3_no_overflow: assert property (@(posedge wr_clk) disable iff (rst)
        (full && !wr_en_n && wr_ld) |=> $stable(wptr));

    // R4: a read while empty does not move the read pointer
    a_r4_no_underflow: assert property (@(posedge rd_clk) disable iff (rst)
        (empty && !rd_en_a_n && !rd_en_b_n) |=> ($stable(rptr) && $stable(rd_q)));

    // R5: one read enable alone pops nothing
    a_r5_single_enable: assert property (@(posedge rd_clk) disable iff (rst)
        (rd_en_a_n != rd_en_b_n) |=> ($stable(rptr) && $stable(rd_q)));

    // R2: the crossing write pointer changes at most one bit per edge
    a_r2_gray_step: assert property (@(posedge wr_clk) disable iff (rst)
        !wr_en_n |=> $onehot0(wgray ^ $past(wgray)));

    // R6: full and almost-full are consistent
    a_r6_full_implies_af: assert property (@(posedge wr_clk) disable iff (rst)
        full |-> almost_full);
endmodule

bind dcfifo_pflag dcf_chk #(.CNT_W(CNT_W)) u_chk (
    .wr_clk       (wr_clk),
    .rd_clk       (rd_clk),
    .rst          (rst),
    .wr_en_n      (wr_en_n),
    .wr_ld        (wr_ld),
    .rd_en_a_n    (rd_en_a_n),
    .rd_en_b_n    (rd_en_b_n),
    .full         (full),
    .almost_full  (almost_full),
    .empty        (empty),
    .almost_empty (almost_empty),
    .wptr         (wptr_bin),
    .rptr         (rptr_bin),
    .wgray        (wgray),
    .rd_q         (rd_q)
);

// File: tb/dcfifo_pflag_tb.sv
module dcfifo_pflag_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en_n = 1'b1;
    logic       wr_ld = 1'b1;
    logic [8:0] wr_data = '0;
    logic       rd_en_a_n = 1'b1;
    logic       rd_en_b_n = 1'b1;
    logic       out_en = 1'b1;
    logic [8:0] rd_data;
    logic       rd_drive;
    logic       empty, almost_empty, almost_full, full;

    int n_checks = 0;
    int n_errors = 0;
    logic [8:0] wseq = '0;
    logic [8:0] rseq = '0;

    always #2.5 clk = ~clk;   // 200 MHz, both ports tied to one clock

    dcfifo_pflag u_dut (
        .wr_clk (clk), .rd_clk (clk), .rst (rst),
        .wr_en_n (wr_en_n), .wr_ld (wr_ld), .wr_data (wr_data),
        .rd_en_a_n (rd_en_a_n), .rd_en_b_n (rd_en_b_n), .out_en (out_en),
        .rd_data (rd_data), .rd_drive (rd_drive),
        .empty (empty), .almost_empty (almost_empty),
        .almost_full (almost_full), .full (full)
    );

    // Stimulus table: op (1 = read burst), burst length, expected {E,AE,AF,F}
    typedef struct packed {
        logic       is_rd;
        logic [7:0] n;
        logic [3:0] exp_flags;
    } step_t;

    localparam int N_STEPS = 8;
    localparam step_t STEPS [N_STEPS] = '{
        '{1'b0, 8'd5,  4'b0100},
        '{1'b0, 8'd3,  4'b0000},
        '{1'b0, 8'd48, 4'b0000},
        '{1'b0, 8'd1,  4'b0010},
        '{1'b0, 8'd7,  4'b0011},
        '{1'b1, 8'd1,  4'b0010},
        '{1'b1, 8'd56, 4'b0100},
        '{1'b1, 8'd7,  4'b1100}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic ld_level);
        @(negedge clk);
        rst = 1'b1; wr_en_n = 1'b1; wr_ld = ld_level;
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        settle(3);
        rst = 1'b0;
        wseq = '0; rseq = '0;
    endtask

    task automatic wr_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en_n = 1'b0; wr_ld = 1'b1; wr_data = wseq;
            wseq = wseq + 1'b1;
        end
        @(negedge clk);
        wr_en_n = 1'b1;
    endtask

    task automatic rd_burst(input int n, input string req);
        @(negedge clk);
        rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(req, 32'(rd_data), 32'(rseq));
            rseq = rseq + 1'b1;
            if (i == n - 1) begin
                rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
            end
        end
    endtask

    function automatic logic [31:0] flag_vec();
        return {28'd0, empty, almost_empty, almost_full, full};
    endfunction

    initial begin
        #500000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [8:0] held;

        // R1: reset state
        settle(2);
        chk("R1 flags during reset", flag_vec(), 32'b1100);
        do_reset(1'b1);
        @(negedge clk);
        chk("R1 flags after reset", flag_vec(), 32'b1100);
        chk("R1 rd_data after reset", 32'(rd_data), 32'd0);
        chk("R1 rd_drive", 32'(rd_drive), 32'd1);

        // R2/R6/R7: table-driven bursts with default offsets of 7
        for (int s = 0; s < N_STEPS; s++) begin
            if (STEPS[s].is_rd) rd_burst(int'(STEPS[s].n), "R2 read order");
            else                wr_burst(int'(STEPS[s].n));
            settle(4);
            chk("R6/R7 flags after table step", flag_vec(), 32'(STEPS[s].exp_flags));
        end

        // R4: read while empty leaves output alone
        held = rd_data;
        @(negedge clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
        settle(3);
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
        @(negedge clk);
        chk("R4 rd_data after empty read", 32'(rd_data), 32'(held));
        chk("R4 still empty", 32'(empty), 32'd1);

        // R5: a single read enable pops nothing
        wr_burst(2);
        settle(4);
        @(negedge clk); rd_en_a_n = 1'b0; rd_en_b_n = 1'b1;
        settle(3);
        rd_en_a_n = 1'b1; rd_en_b_n = 1'b0;
        settle(3);
        rd_en_b_n = 1'b1;
        @(negedge clk);
        chk("R5 rd_data unchanged", 32'(rd_data), 32'(held));
        chk("R5 not empty", 32'(empty), 32'd0);
        rd_burst(2, "R5 nothing lost");

        // R9: output enable
        held = rd_data;
        @(negedge clk); out_en = 1'b0;
        @(negedge clk);
        chk("R9 rd_data released", 32'(rd_data), 32'd0);
        chk("R9 rd_drive low", 32'(rd_drive), 32'd0);
        out_en = 1'b1;
        @(negedge clk);
        chk("R9 word kept", 32'(rd_data), 32'(held));

        // R3: writes discarded while full
        do_reset(1'b1);
        wr_burst(64);
        settle(4);
        chk("R3 full after 64 writes", flag_vec(), 32'b0011);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); wr_en_n = 1'b0; wr_ld = 1'b1; wr_data = 9'h1AA;
        end
        @(negedge clk); wr_en_n = 1'b1;
        settle(4);
        chk("R3 still full", 32'(full), 32'd1);
        rd_burst(64, "R3 contents intact");
        settle(4);
        chk("R3/R6 empty after draining", flag_vec(), 32'b1100);

        // R8: offset load after a reset with wr_ld low
        do_reset(1'b0);
        @(negedge clk); wr_en_n = 1'b0; wr_ld = 1'b0; wr_data = 9'd2;
        @(negedge clk); wr_data = 9'd3;
        @(negedge clk); wr_en_n = 1'b1; wr_ld = 1'b1;
        settle(4);
        chk("R8 empty after load", flag_vec(), 32'b1100);
        wr_burst(2);
        settle(4);
        chk("R8 ae at offset 2", flag_vec(), 32'b0100);
        wr_burst(1);
        settle(4);
        chk("R8 ae clear above 2", flag_vec(), 32'b0000);
        wr_burst(57);
        settle(4);
        chk("R8 af clear at vacancy 4", flag_vec(), 32'b0000);
        wr_burst(1);
        settle(4);
        chk("R8 af set at vacancy 3", flag_vec(), 32'b0010);
        rd_burst(3, "R8 data path in load mode");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule